// File: doc/BRIEF.md
# Ternary 3x3 Convolution Engine

This block performs one layer pass of a ternary convolutional network using a single, time-multiplexed datapath. Every weight and every activation is one of -1, 0 or +1. The block therefore multiplies nothing. For each weight it adds the activation to a signed integer accumulator, subtracts it, or leaves the accumulator alone. After all 3x3 taps of all input channels for one output pixel have been summed, a programmable threshold turns the sum back into a ternary value. The result is written to an output memory.

Before a pass, a host fills an activation memory and a weight memory and sets the threshold. It then pulses `start`. The engine visits the output pixels one by one, in channel-major, row, column order, and reports completion with a one-cycle `done`. A different layer runs on the same hardware once the weight memory has been reloaded and the block started again. Both memories are read combinationally: the engine presents an address and uses the data in the same cycle.

Top module: `tconv3_engine`

## Requirements
- R1: Ternary codes are 2'b01 = +1, 2'b11 = -1 and 2'b00 = 0. An input code 2'b10 is read as 0, and `out_data` only ever carries 2'b00, 2'b01 or 2'b11.
- R2: A weight of +1 adds the activation to the pixel sum, a weight of -1 subtracts it, and a weight of 0 leaves the sum unchanged.
- R3: The convolution has stride 1 and zero padding. Tap (ky,kx), with ky and kx in 0..2, reads input row y+ky-1 and column x+kx-1. A tap outside the image contributes 0. The output has the same height and width as the input.
- R4: With threshold T, the output is +1 when sum > T and -1 when sum < -T. Otherwise it is 0, including when sum equals T or -T.
- R5: Each output pixel is written exactly once, in the order of `out_addr` = (co*H + y)*W + x. The output channel varies slowest and the column fastest.
- R6: `done` is high for exactly one cycle, the cycle after the last output write. `busy` is high from the cycle after the accepted `start` through that `done` cycle. After reset, both `busy` and `done` are low.
- R7: A `start` pulse while `busy` is high is ignored. It does not change the timing or the results of the running pass.
- R8: The sum holds 9*CIN terms of the same sign without overflow.
- R9: Passes are independent. A second pass with new weights gives exactly the results of those new weights.
- R10: Each output pixel takes 9*CIN+1 cycles. Memory addresses are `act_addr` = (ci*H + iy)*W + ix and `wt_addr` = (co*CIN + ci)*9 + ky*3 + kx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a pass when the block is idle |
| thr | input | THR_W | Unsigned threshold T |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pass completion |
| act_addr | output | ACT_AW | Activation memory address |
| act_data | input | 2 | Activation code read at `act_addr` |
| wt_addr | output | WT_AW | Weight memory address |
| wt_data | input | 2 | Weight code read at `wt_addr` |
| out_we | output | 1 | Output memory write strobe |
| out_addr | output | OUT_AW | Output memory address |
| out_data | output | 2 | Ternary output code |

## Verification
A wrong tap counter or a wrong padding test changes the sum of a border or interior pixel. It shows up as a wrong code at that pixel's `out_addr` in the first pass that uses a pattern sensitive to it. A slip in the pixel counters shows up at the next write as an out-of-order `out_addr`. A wrong state transition shows as a pass whose length differs from COUT*H*W*(9*CIN+1) cycles, or as a `done` that lasts more than one cycle. An accumulator that is not cleared at each pixel corrupts the second pixel of a pass, and a run with all-ones data exposes an accumulator that is too narrow.

// File: rtl/tconv_pkg.sv
package tconv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SUM   = 2'd1,
      ST_WRITE = 2'd2,
      ST_FIN   = 2'd3
   } tconv_state_e;

   // signed value of a ternary code; 2'b10 reads as zero
   function automatic logic signed [1:0] tern_val(input logic [1:0] code);
      case (code)
         2'b01:   return 2'sd1;
         2'b11:   return -2'sd1;
         default: return 2'sd0;
      endcase
   endfunction

   // signed product of two ternary codes, without a multiplier
   function automatic logic signed [1:0] tern_prod(input logic [1:0] w, input logic [1:0] a);
      logic signed [1:0] wv, av;
      wv = tern_val(w);
      av = tern_val(a);
      if (wv == 2'sd0 || av == 2'sd0) return 2'sd0;
      else if (wv == 2'sd1)           return av;
      else                            return -av;
   endfunction

endpackage

// File: rtl/tconv_seq.sv
module tconv_seq #(
   parameter int H    = 4,
   parameter int W    = 5,
   parameter int CIN  = 2,
   parameter int COUT = 3,
   localparam int Y_W  = $clog2(H > 1 ? H : 2),
   localparam int X_W  = $clog2(W > 1 ? W : 2),
   localparam int CI_W = $clog2(CIN > 1 ? CIN : 2),
   localparam int CO_W = $clog2(COUT > 1 ? COUT : 2)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   output logic [CO_W-1:0] co,
   output logic [Y_W-1:0]  y,
   output logic [X_W-1:0]  x,
   output logic [CI_W-1:0] ci,
   output logic [1:0]      ky,
   output logic [1:0]      kx,
   output logic            sum_en,
   output logic            sum_first,
   output logic            wr,
   output logic            fin,
   output logic            busy
);
   import tconv_pkg::*;

   tconv_state_e state;

   wire last_term  = (kx == 2'd2) && (ky == 2'd2) && (ci == CI_W'(CIN - 1));
   wire last_pixel = (x == X_W'(W - 1)) && (y == Y_W'(H - 1)) && (co == CO_W'(COUT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         co <= '0; y <= '0; x <= '0; ci <= '0; ky <= '0; kx <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               state <= ST_SUM;
               co <= '0; y <= '0; x <= '0; ci <= '0; ky <= '0; kx <= '0;
            end
            ST_SUM: begin
               if (last_term) begin
                  state <= ST_WRITE;
                  kx <= '0; ky <= '0; ci <= '0;
               end else if (kx != 2'd2) begin
                  kx <= kx + 2'd1;
               end else begin
                  kx <= '0;
                  if (ky != 2'd2) ky <= ky + 2'd1;
                  else begin
                     ky <= '0;
                     ci <= ci + CI_W'(1);
                  end
               end
            end
            ST_WRITE: begin
               if (last_pixel) state <= ST_FIN;
               else begin
                  state <= ST_SUM;
                  if (x != X_W'(W - 1)) x <= x + X_W'(1);
                  else begin
                     x <= '0;
                     if (y != Y_W'(H - 1)) y <= y + Y_W'(1);
                     else begin
                        y  <= '0;
                        co <= co + CO_W'(1);
                     end
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign sum_en    = (state == ST_SUM);
   assign sum_first = sum_en && (kx == 2'd0) && (ky == 2'd0) && (ci == '0);
   assign wr        = (state == ST_WRITE);
   assign fin       = (state == ST_FIN);
   assign busy      = (state != ST_IDLE);

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fin |=> !fin); // R6
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SUM && start) |=> (state != ST_IDLE) && $stable(co) && $stable(y) && $stable(x)); // R7
   AST_WRITE_FOLLOWS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WRITE) |-> ($past(state) == ST_SUM)); // R10
   AST_FIN_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fin) |-> ($past(state) == ST_WRITE)); // R6

endmodule

// File: rtl/tconv_acc.sv
module tconv_acc #(
   parameter int CIN = 2,
   localparam int MAX_SUM = 9 * CIN,
   localparam int ACC_W = $clog2(MAX_SUM + 1) + 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    first,
   input  logic [1:0]              w_code,
   input  logic [1:0]              a_code,
   output logic signed [ACC_W-1:0] acc
);
   import tconv_pkg::*;

   logic signed [ACC_W-1:0] term;
   assign term = ACC_W'(tern_prod(w_code, a_code));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc <= '0;
      else if (en) begin
         if (first)   acc <= term;
         else         acc <= acc + term;
      end
   end

   AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (acc <= ACC_W'(MAX_SUM)) && (acc >= -ACC_W'(MAX_SUM))); // R8
   AST_SKIP_ZERO_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !first && (w_code == 2'b00)) |=> $stable(acc)); // R2

endmodule

// File: rtl/tconv_thr.sv
module tconv_thr #(
   parameter int ACC_W = 6,
   parameter int THR_W = 8,
   localparam int CMP_W = (ACC_W > THR_W ? ACC_W : THR_W) + 2
) (
   input  logic signed [ACC_W-1:0] acc,
   input  logic [THR_W-1:0]        thr,
   output logic [1:0]              code
);
   logic signed [CMP_W-1:0] s, t;

   always_comb begin
      s = CMP_W'(acc);
      t = $signed({{(CMP_W - THR_W){1'b0}}, thr});
      if (s > t)       code = 2'b01;
      else if (s < -t) code = 2'b11;
      else             code = 2'b00;
   end

   always_comb begin
      AST_OUT_CODE_LEGAL: assert (code != 2'b10); // R1
   end

endmodule

// File: rtl/tconv3_engine.sv
module tconv3_engine #(
   parameter int H     = 4,
   parameter int W     = 5,
   parameter int CIN   = 2,
   parameter int COUT  = 3,
   parameter int THR_W = 8,
   localparam int ACT_N  = CIN * H * W,
   localparam int WT_N   = COUT * CIN * 9,
   localparam int OUT_N  = COUT * H * W,
   localparam int ACT_AW = $clog2(ACT_N > 1 ? ACT_N : 2),
   localparam int WT_AW  = $clog2(WT_N),
   localparam int OUT_AW = $clog2(OUT_N > 1 ? OUT_N : 2),
   localparam int ACC_W  = $clog2(9 * CIN + 1) + 1,
   localparam int Y_W    = $clog2(H > 1 ? H : 2),
   localparam int X_W    = $clog2(W > 1 ? W : 2),
   localparam int CI_W   = $clog2(CIN > 1 ? CIN : 2),
   localparam int CO_W   = $clog2(COUT > 1 ? COUT : 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [THR_W-1:0]  thr,
   output logic              busy,
   output logic              done,
   output logic [ACT_AW-1:0] act_addr,
   input  logic [1:0]        act_data,
   output logic [WT_AW-1:0]  wt_addr,
   input  logic [1:0]        wt_data,
   output logic              out_we,
   output logic [OUT_AW-1:0] out_addr,
   output logic [1:0]        out_data
);

   generate
      if (H < 1 || W < 1)      begin : g_bad_dim  $error("image dimensions must be positive"); end
      if (CIN < 1 || COUT < 1) begin : g_bad_chan $error("channel counts must be positive");   end
      if (THR_W < 1)           begin : g_bad_thr  $error("threshold width must be positive");  end
   endgenerate

   logic [CO_W-1:0] co;
   logic [Y_W-1:0]  y;
   logic [X_W-1:0]  x;
   logic [CI_W-1:0] ci;
   logic [1:0]      ky, kx;
   logic            sum_en, sum_first, wr;
   logic            tap_in;
   logic [1:0]      a_masked;
   logic signed [ACC_W-1:0] acc;

   tconv_seq #(.H(H), .W(W), .CIN(CIN), .COUT(COUT)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .co(co), .y(y), .x(x), .ci(ci), .ky(ky), .kx(kx),
      .sum_en(sum_en), .sum_first(sum_first), .wr(wr), .fin(done), .busy(busy)
   );

   // tap position with zero padding
   always_comb begin
      int iy, ix;
      iy = int'(y) + int'(ky) - 1;
      ix = int'(x) + int'(kx) - 1;
      tap_in   = (iy >= 0) && (iy < H) && (ix >= 0) && (ix < W);
      act_addr = tap_in ? ACT_AW'((int'(ci) * H + iy) * W + ix) : '0;
      wt_addr  = WT_AW'((int'(co) * CIN + int'(ci)) * 9 + int'(ky) * 3 + int'(kx));
      out_addr = OUT_AW'((int'(co) * H + int'(y)) * W + int'(x));
   end

   assign a_masked = tap_in ? act_data : 2'b00;

   tconv_acc #(.CIN(CIN)) u_acc (
      .clk(clk), .rst_n(rst_n), .en(sum_en), .first(sum_first),
      .w_code(wt_data), .a_code(a_masked), .acc(acc)
   );

   tconv_thr #(.ACC_W(ACC_W), .THR_W(THR_W)) u_thr (
      .acc(acc), .thr(thr), .code(out_data)
   );

   assign out_we = wr;

   AST_WADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_we |-> (int'(out_addr) < OUT_N)); // R5
   AST_WE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      out_we |-> busy && !done); // R6
   AST_PAD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (sum_en && !tap_in) |-> (a_masked == 2'b00)); // R3

endmodule

// File: tb/tb_tconv3_engine.sv
module tb_tconv3_engine;
   localparam int H = 4, W = 5, CIN = 2, COUT = 3, THR_W = 8;
   localparam int ACT_N = CIN * H * W, WT_N = COUT * CIN * 9, OUT_N = COUT * H * W;
   localparam int ACT_AW = $clog2(ACT_N), WT_AW = $clog2(WT_N), OUT_AW = $clog2(OUT_N);
   localparam int PASS_CYC = OUT_N * (9 * CIN + 1);

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic [THR_W-1:0] thr = '0;
   logic busy, done, out_we;
   logic [ACT_AW-1:0] act_addr;
   logic [WT_AW-1:0]  wt_addr;
   logic [OUT_AW-1:0] out_addr;
   logic [1:0] act_data, wt_data, out_data;

   logic [1:0] act_mem [0:(1<<ACT_AW)-1];
   logic [1:0] wt_mem  [0:(1<<WT_AW)-1];
   logic [1:0] out_mem [0:(1<<OUT_AW)-1];
   int n_checks = 0, n_fail = 0, wr_idx = 0, order_err = 0;
   logic [31:0] seed = 32'h1234_5678;

   always #2.5 clk = ~clk;

   assign act_data = act_mem[act_addr];
   assign wt_data  = wt_mem[wt_addr];

   tconv3_engine #(.H(H), .W(W), .CIN(CIN), .COUT(COUT), .THR_W(THR_W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .thr(thr), .busy(busy), .done(done),
      .act_addr(act_addr), .act_data(act_data), .wt_addr(wt_addr), .wt_data(wt_data),
      .out_we(out_we), .out_addr(out_addr), .out_data(out_data)
   );

   always @(negedge clk) if (out_we) begin
      if (int'(out_addr) != wr_idx) order_err++;
      out_mem[out_addr] = out_data;
      wr_idx++;
   end

   function automatic int val(input logic [1:0] c);
      return (c == 2'b01) ? 1 : (c == 2'b11) ? -1 : 0;
   endfunction

   function automatic logic [1:0] next_code();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed[17:16];
   endfunction

   task automatic check(input string req, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
      end
   endtask

   // mode: 0 random, 1 all +1, 2 weights -1 acts +1
   task automatic load(input int mode, input bit acts_too);
      if (acts_too) for (int i = 0; i < ACT_N; i++) act_mem[i] = (mode == 0) ? next_code() : 2'b01;
      for (int i = 0; i < WT_N; i++)
         wt_mem[i] = (mode == 0) ? next_code() : (mode == 1) ? 2'b01 : 2'b11;
   endtask

   task automatic run_pass(input int t, input string tag, input bit poke_start);
      int cyc;
      thr = THR_W'(t);
      wr_idx = 0; order_err = 0;
      for (int i = 0; i < OUT_N; i++) out_mem[i] = 2'b10;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      check("R6 busy after start", int'(busy), 1);
      cyc = 1;
      while (!done && cyc < 3 * PASS_CYC) begin
         @(negedge clk);
         cyc++;
         if (poke_start && cyc == 200) start = 1'b1;
         if (poke_start && cyc == 201) start = 1'b0;
      end
      check({"R10 R7 pass length ", tag}, cyc, PASS_CYC + 1);
      @(negedge clk);
      check("R6 done one cycle", int'(done), 0);
      check("R6 idle after done", int'(busy), 0);
      check({"R5 write count ", tag}, wr_idx, OUT_N);
      check({"R5 write order ", tag}, order_err, 0);
      for (int co = 0; co < COUT; co++)
         for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++) begin
               int s, e;
               s = 0;
               for (int ci = 0; ci < CIN; ci++)
                  for (int ky = 0; ky < 3; ky++)
                     for (int kx = 0; kx < 3; kx++) begin
                        int iy, ix;
                        iy = y + ky - 1; ix = x + kx - 1;
                        if (iy >= 0 && iy < H && ix >= 0 && ix < W)
                           s += val(wt_mem[(co * CIN + ci) * 9 + ky * 3 + kx]) *
                                val(act_mem[(ci * H + iy) * W + ix]);
                     end
               e = (s > t) ? 1 : (s < -t) ? 3 : 0;
               check({"R1 R2 R3 R4 R8 R9 pixel ", tag},
                     int'(out_mem[(co * H + y) * W + x]), e);
            end
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R6 reset busy", int'(busy), 0);
      check("R6 reset done", int'(done), 0);
      check("R5 reset we", int'(out_we), 0);
      rst_n = 1'b1;
      @(negedge clk);
      load(0, 1'b1); run_pass(1, "random T1", 1'b0);
      load(1, 1'b1); run_pass(17, "all+1 T17", 1'b0);   // interior 18 > 17: R8 full range
      load(1, 1'b1); run_pass(18, "all+1 T18", 1'b0);   // sum equals T gives 0: R4
      load(2, 1'b1); run_pass(17, "w-1 T17", 1'b0);
      load(0, 1'b1); run_pass(0, "random T0", 1'b0);
      load(0, 1'b0); run_pass(2, "reload T2 R9", 1'b1);  // new weights, start poked mid-pass: R7
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule